// File: doc/BRIEF.md
# Shared-RAM Ownership and Memory-Mode Register

This block holds the control state for a RAM region that two processors share: a main processor and a sub processor. Each processor reaches the register through its own 16-bit port, which has byte lanes. Each port has its own read layout and its own write rights. Ownership of the RAM does not change through a plain write. The main side gives the RAM away by raising a swap request, and the sub side gives it back by setting a return flag.

Besides ownership, the register holds four more fields. The main side sets a 2-bit bank select for its window into the sub processor's program RAM, and an 8-bit write-protect mask. The sub side sets a mode bit and a 2-bit priority mode. All fields are also driven out as plain outputs, so that address decode and arbitration logic elsewhere can use them. Read data is combinational from the stored state, and a write takes effect on the next clock edge.

Top module: `shmem_mode_reg`

## Requirements
- R1: After reset, ownership, bank, mode, priority and write-protect are all 0, and both ports read 0x0002.
- R2: The main port reads write-protect in [15:8], bank in [7:6], mode in [2], the swap flag in [1] and the ownership flag in [0]. Bit 1 always reads as the inverse of bit 0.
- R3: A main write with byte lane 0 enabled and data bit 1 at 1 clears ownership on the next edge.
- R4: A main write with lane 0 enabled loads bank from data [7:6]. A main write with lane 1 enabled loads write-protect from data [15:8]. A lane that is not enabled leaves its fields unchanged.
- R5: A sub write with lane 0 enabled and data bit 0 at 1 sets ownership on the next edge.
- R6: A sub write with lane 0 enabled loads mode from data bit 2 and priority from data [4:3].
- R7: The sub port reads write-protect in [15:8], priority in [4:3], mode in [2], the swap flag in [1] and ownership in [0]. Bits [7:5] always read 0, so the bank is not visible.
- R8: Sub writes never change write-protect or bank. Main writes never change mode or priority, and never set ownership.
- R9: Data bits with no meaning for the writing port have no effect: main bits 0, 2 and [5:3], and sub bits 1, [7:5] and [15:8]. Unused read positions return 0.
- R10: If a main swap request and a sub return occur in the same cycle, ownership ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_wr | input | 1 | Main port write strobe |
| main_be | input | 2 | Main port byte enables (bit 0 = [7:0]) |
| main_wdata | input | 16 | Main port write data |
| main_rdata | output | 16 | Main port read view |
| sub_wr | input | 1 | Sub port write strobe |
| sub_be | input | 2 | Sub port byte enables (bit 0 = [7:0]) |
| sub_wdata | input | 16 | Sub port write data |
| sub_rdata | output | 16 | Sub port read view |
| main_owns | output | 1 | Main processor owns the shared RAM |
| bank_sel | output | 2 | Main window bank into sub program RAM |
| ram_mode | output | 1 | RAM mode bit |
| prio_mode | output | 2 | Priority mode |
| wprot | output | 8 | Write-protect mask |

## Verification
The main swap request and the sub return can land on the same clock edge, and only one of them can decide ownership. Directed steps drive both ports with their ownership bits set in the same cycle, starting from each ownership state. Random stimulus also makes the two writes collide often. The check is that ownership reads as set afterwards on both ports, while the other fields written in that same cycle still load from their own lanes.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  localparam int DW      = 16;
  localparam int WP_W    = 8;
  localparam int BANK_W  = 2;
  localparam int PRIO_W  = 2;
  localparam int OWN_BIT  = 0;
  localparam int SWAP_BIT = 1;
  localparam int MODE_BIT = 2;
  localparam int PRIO_LSB = 3;
  localparam int BANK_LSB = 6;
  localparam int WP_LSB   = 8;

  function automatic logic [DW-1:0] main_view(input logic [WP_W-1:0] wp,
                                               input logic [BANK_W-1:0] bank,
                                               input logic mode, input logic own);
    logic [DW-1:0] v;
    v = '0;
    v[WP_LSB +: WP_W]     = wp;
    v[BANK_LSB +: BANK_W] = bank;
    v[MODE_BIT]           = mode;
    v[SWAP_BIT]           = ~own;
    v[OWN_BIT]            = own;
    return v;
  endfunction

  function automatic logic [DW-1:0] sub_view(input logic [WP_W-1:0] wp,
                                              input logic [PRIO_W-1:0] prio,
                                              input logic mode, input logic own);
    logic [DW-1:0] v;
    v = '0;
    v[WP_LSB +: WP_W]     = wp;
    v[PRIO_LSB +: PRIO_W] = prio;
    v[MODE_BIT]           = mode;
    v[SWAP_BIT]           = ~own;
    v[OWN_BIT]            = own;
    return v;
  endfunction
endpackage

// File: rtl/shmem_own_hs.sv
module shmem_own_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic ret_evt,
  output logic own
);
  always_ff @(posedge clk) begin
    if (!rst_n)        own <= 1'b0;
    else if (ret_evt)  own <= 1'b1;
    else if (swap_req) own <= 1'b0;
  end

  assert_return_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> own);
  assert_swap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !ret_evt) |=> !own);
  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && ret_evt) |=> own);
  assert_own_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_req && !ret_evt) |=> $stable(own));
endmodule

// File: rtl/shmem_main_side.sv
module shmem_main_side
  import shmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        be,
  input  logic [WP_W-1:0]   wp_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              swap_in,
  output logic              swap_req,
  output logic [BANK_W-1:0] bank,
  output logic [WP_W-1:0]   wp
);
  logic lo_wr, hi_wr;
  assign lo_wr    = wr & be[0];
  assign hi_wr    = wr & be[1];
  assign swap_req = lo_wr & swap_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
      wp   <= '0;
    end else begin
      if (lo_wr) bank <= bank_in;
      if (hi_wr) wp   <= wp_in;
    end
  end

  assert_wp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be[1]) |=> wp == $past(wp_in));
  assert_wp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be[1]) |=> $stable(wp));
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be[0]) |=> $stable(bank));
endmodule

// File: rtl/shmem_sub_side.sv
module shmem_sub_side
  import shmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              be_lo,
  input  logic              mode_in,
  input  logic [PRIO_W-1:0] prio_in,
  input  logic              ret_in,
  output logic              ret_evt,
  output logic              mode,
  output logic [PRIO_W-1:0] prio
);
  logic lo_wr;
  assign lo_wr   = wr & be_lo;
  assign ret_evt = lo_wr & ret_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 1'b0;
      prio <= '0;
    end else if (lo_wr) begin
      mode <= mode_in;
      prio <= prio_in;
    end
  end

  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be_lo) |=> (mode == $past(mode_in)) && (prio == $past(prio_in)));
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be_lo) |=> $stable(mode) && $stable(prio));
endmodule

// File: rtl/shmem_mode_reg.sv
module shmem_mode_reg
  import shmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_wr,
  input  logic [1:0]        main_be,
  input  logic [DW-1:0]     main_wdata,
  output logic [DW-1:0]     main_rdata,
  input  logic              sub_wr,
  input  logic [1:0]        sub_be,
  input  logic [DW-1:0]     sub_wdata,
  output logic [DW-1:0]     sub_rdata,
  output logic              main_owns,
  output logic [BANK_W-1:0] bank_sel,
  output logic              ram_mode,
  output logic [PRIO_W-1:0] prio_mode,
  output logic [WP_W-1:0]   wprot
);
  logic swap_req, ret_evt;

  shmem_main_side u_main (
    .clk(clk), .rst_n(rst_n), .wr(main_wr), .be(main_be),
    .wp_in(main_wdata[WP_LSB +: WP_W]), .bank_in(main_wdata[BANK_LSB +: BANK_W]),
    .swap_in(main_wdata[SWAP_BIT]), .swap_req(swap_req),
    .bank(bank_sel), .wp(wprot)
  );

  shmem_sub_side u_sub (
    .clk(clk), .rst_n(rst_n), .wr(sub_wr), .be_lo(sub_be[0]),
    .mode_in(sub_wdata[MODE_BIT]), .prio_in(sub_wdata[PRIO_LSB +: PRIO_W]),
    .ret_in(sub_wdata[OWN_BIT]), .ret_evt(ret_evt),
    .mode(ram_mode), .prio(prio_mode)
  );

  shmem_own_hs u_own (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .ret_evt(ret_evt), .own(main_owns)
  );

  assign main_rdata = main_view(wprot, bank_sel, ram_mode, main_owns);
  assign sub_rdata  = sub_view(wprot, prio_mode, ram_mode, main_owns);

  // Data bits that carry no meaning for their port (R9).
  logic unused_bits;
  assign unused_bits = ^{main_wdata[OWN_BIT], main_wdata[MODE_BIT], main_wdata[5:3],
                         sub_wdata[SWAP_BIT], sub_wdata[15:5], sub_be[1]};

  assert_swap_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    main_rdata[SWAP_BIT] != main_owns);
  assert_bank_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rdata[7:5] == 3'b000);
  assert_main_gap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    main_rdata[5:3] == 3'b000);
endmodule

// File: tb/shmem_mode_reg_test.sv
module shmem_mode_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_wr = 1'b0, sub_wr = 1'b0;
  logic [1:0] main_be = '0, sub_be = '0;
  logic [15:0] main_wdata = '0, sub_wdata = '0;
  logic [15:0] main_rdata, sub_rdata;
  logic main_owns, ram_mode;
  logic [1:0] bank_sel, prio_mode;
  logic [7:0] wprot;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_own; bit [1:0] m_bank, m_prio; bit m_mode; bit [7:0] m_wp;

  always #10 clk = ~clk;

  shmem_mode_reg uut (
    .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .main_be(main_be),
    .main_wdata(main_wdata), .main_rdata(main_rdata), .sub_wr(sub_wr),
    .sub_be(sub_be), .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
    .main_owns(main_owns), .bank_sel(bank_sel), .ram_mode(ram_mode),
    .prio_mode(prio_mode), .wprot(wprot)
  );

  function automatic bit [15:0] exp_main();
    return (16'(m_wp) << 8) | (16'(m_bank) << 6) | (16'(m_mode) << 2)
         | (16'(!m_own) << 1) | 16'(m_own);
  endfunction

  function automatic bit [15:0] exp_sub();
    return (16'(m_wp) << 8) | (16'(m_prio) << 3) | (16'(m_mode) << 2)
         | (16'(!m_own) << 1) | 16'(m_own);
  endfunction

  task automatic check(input string tag);
    bit [15:0] em, es, eo, ao;
    em = exp_main(); es = exp_sub();
    eo = {m_wp, m_bank, m_prio, m_mode, m_own, 2'b00};
    ao = {wprot, bank_sel, prio_mode, ram_mode, main_owns, 2'b00};
    checks++;
    if (main_rdata !== em || sub_rdata !== es || ao !== eo) begin
      errors++;
      $display("FAIL %s main %h/%h sub %h/%h fields %h/%h", tag,
               main_rdata, em, sub_rdata, es, ao, eo);
    end
  endtask

  task automatic step(input bit mw, input bit [1:0] mbe, input bit [15:0] md,
                      input bit sw, input bit [1:0] sbe, input bit [15:0] sd,
                      input string tag);
    bit nown;
    main_wr = mw; main_be = mbe; main_wdata = md;
    sub_wr = sw; sub_be = sbe; sub_wdata = sd;
    @(posedge clk);
    nown = m_own;
    if (mw && mbe[0]) begin m_bank = md[7:6]; if (md[1]) nown = 0; end
    if (mw && mbe[1]) m_wp = md[15:8];
    if (sw && sbe[0]) begin m_mode = sd[2]; m_prio = sd[4:3]; if (sd[0]) nown = 1; end
    m_own = nown;
    @(negedge clk);
    main_wr = 0; sub_wr = 0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_own = 0; m_bank = 0; m_prio = 0; m_mode = 0; m_wp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset state");
    checks++;
    if (main_rdata !== 16'h0002 || sub_rdata !== 16'h0002) begin
      errors++; $display("FAIL R1 main %h sub %h exp 0002", main_rdata, sub_rdata);
    end
    // sub return, then main swap
    step(0, 2'b00, 16'h0, 1, 2'b01, 16'h0001, "R5 sub return");
    step(1, 2'b01, 16'h0002, 0, 2'b00, 16'h0, "R3 main swap");
    // main loads bank and wp by lane
    step(1, 2'b01, 16'h00C0, 0, 2'b00, 16'h0, "R4 bank lane0");
    step(1, 2'b10, 16'hA5FF, 0, 2'b00, 16'h0, "R4 wp lane1 only");
    step(1, 2'b11, 16'h3C40, 0, 2'b00, 16'h0, "R2 R4 both lanes");
    // sub mode/prio
    step(0, 2'b00, 16'h0, 1, 2'b01, 16'h001C, "R6 R7 mode prio");
    // illegal bits
    step(1, 2'b01, 16'h003D, 0, 2'b00, 16'h0, "R8 R9 main sets own/mode");
    step(0, 2'b00, 16'h0, 1, 2'b11, 16'hFFE2, "R8 R9 sub high byte and junk");
    step(0, 2'b00, 16'h0, 1, 2'b10, 16'hFFFF, "R8 sub lane1 only");
    // collisions from both ownership states
    step(1, 2'b01, 16'h0002, 1, 2'b01, 16'h0001, "R10 collision own0");
    step(1, 2'b11, 16'h5582, 1, 2'b01, 16'h000D, "R10 collision own1");
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 1), 2'($urandom), 16'($urandom),
           $urandom_range(0, 1), 2'($urandom), 16'($urandom), "R2 R7 R10 random");
    end
    rst_n = 0;
    @(posedge clk);
    m_own = 0; m_bank = 0; m_prio = 0; m_mode = 0; m_wp = 0;
    @(negedge clk);
    rst_n = 1;
    check("R1 second reset");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule